// File: doc/BRIEF.md
# Designator-Selected Scratchpad Register Array

This block holds sixteen 16-bit scratchpad registers for a small processor datapath. It acts on exactly one register per cycle. The index of that register comes from one of three 4-bit designator values, named N, P and X. A 2-bit source-select input picks which designator is used. The selected register is always visible in full on the 16-bit address output. One of its two bytes, picked by a byte-select input, is visible on the 8-bit byte output.

A 3-bit operation code decides what is written back to the selected register at the next clock edge. The register can be left alone, incremented by one, decremented by one, or have its low or high byte replaced from the 8-bit byte input. Both outputs are combinational reads of the register contents. In a cycle that also updates the register, they still show the value from before the update. Instruction decode is outside this block.

Reset is asynchronous and active low. It is released synchronously through a two-stage synchronizer and clears every register to zero.

Top module: `spad_regfile`

## Requirements
- R1: While reset is applied, and after it is released, every register reads as 0x0000 until an operation writes it.
- R2: The register index comes from `src_sel`: 0 selects `desig_n`, 1 selects `desig_p`, 2 selects `desig_x`, and 3 also selects `desig_n`.
- R3: `addr_out` carries all 16 bits of the selected register.
- R4: `byte_out` carries bits 15:8 of the selected register when `byte_hi` is 1, and bits 7:0 when `byte_hi` is 0.
- R5: Operation code 1 (increment) writes the selected value plus one back to the same register at the clock edge. 0xFFFF becomes 0x0000.
- R6: Operation code 2 (decrement) writes the selected value minus one back to the same register. 0x0000 becomes 0xFFFF.
- R7: Operation code 3 (load low) replaces bits 7:0 of the selected register with `byte_in`. Bits 15:8 are kept.
- R8: Operation code 4 (load high) replaces bits 15:8 of the selected register with `byte_in`. Bits 7:0 are kept.
- R9: Operation codes 0, 5, 6 and 7 leave every register unchanged. Every operation leaves all unselected registers unchanged.
- R10: In a cycle that writes the selected register, both outputs show the value from before the write. The new value appears after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desig_n | input | 4 | Designator N (register index) |
| desig_p | input | 4 | Designator P (register index) |
| desig_x | input | 4 | Designator X (register index) |
| src_sel | input | 2 | Chooses which designator indexes the array |
| op | input | 3 | Operation on the selected register |
| byte_hi | input | 1 | Chooses the byte routed to `byte_out` |
| byte_in | input | 8 | Byte for the load-low and load-high operations |
| addr_out | output | 16 | Full contents of the selected register |
| byte_out | output | 8 | Chosen byte of the selected register |

## Verification
The read path and the write-back path act on the same register in the same cycle. For example, the address and a byte of a register are read out while that register is incremented, decremented or byte-loaded. The bench provokes this by issuing a write operation and checking both outputs in that same cycle, where the pre-update value is expected. It then checks the next cycle with no operation, where the updated value is expected. It also varies the designator between cycles to confirm that only the addressed register moved.

// File: rtl/spad_pkg.sv
package spad_pkg;

  // Operation applied to the selected register at the clock edge.
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_INC   = 3'd1,
    OP_DEC   = 3'd2,
    OP_LD_LO = 3'd3,
    OP_LD_HI = 3'd4
  } spad_op_e;

  // Designator chosen as the register index.
  typedef enum logic [1:0] {
    SRC_N     = 2'd0,
    SRC_P     = 2'd1,
    SRC_X     = 2'd2,
    SRC_N_ALT = 2'd3
  } spad_src_e;

endpackage

// File: rtl/spad_rst_sync.sv
module spad_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/spad_index_mux.sv
module spad_index_mux #(
  parameter int unsigned IDX_W = 4
) (
  input  logic [1:0]       src_sel,
  input  logic [IDX_W-1:0] desig_n,
  input  logic [IDX_W-1:0] desig_p,
  input  logic [IDX_W-1:0] desig_x,
  output logic [IDX_W-1:0] idx
);
  import spad_pkg::*;

  spad_src_e src;

  always_comb begin
    src = spad_src_e'(src_sel);
    unique case (src)
      SRC_P:   idx = desig_p;
      SRC_X:   idx = desig_x;
      default: idx = desig_n;
    endcase
  end

endmodule

// File: rtl/spad_update.sv
module spad_update #(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [2:0]        op,
  input  logic [REG_W-1:0]  cur,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [REG_W-1:0]  nxt,
  output logic              wr_en
);
  import spad_pkg::*;

  localparam int unsigned HI_LSB = REG_W - BYTE_W;
  localparam logic [REG_W-1:0] ONE = REG_W'(1);

  spad_op_e op_e;

  always_comb begin
    op_e  = spad_op_e'(op);
    nxt   = cur;
    wr_en = 1'b0;
    case (op_e)
      OP_INC: begin
        nxt   = cur + ONE;
        wr_en = 1'b1;
      end
      OP_DEC: begin
        nxt   = cur - ONE;
        wr_en = 1'b1;
      end
      OP_LD_LO: begin
        nxt[BYTE_W-1:0] = byte_in;
        wr_en           = 1'b1;
      end
      OP_LD_HI: begin
        nxt[REG_W-1:HI_LSB] = byte_in;
        wr_en               = 1'b1;
      end
      default: begin
        nxt   = cur;
        wr_en = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/spad_storage.sv
module spad_storage #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned REG_W    = 16,
  parameter int unsigned IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data
);

  logic [REG_W-1:0] regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] row_en;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_row
    assign row_en[g] = wr_en && (idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) begin
        regs_q[g] <= '0;
      end else if (row_en[g]) begin
        regs_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IDX_W'(i)) begin
        rd_data = regs_q[i];
      end
    end
  end

endmodule

// File: rtl/spad_regfile.sv
module spad_regfile #(
  parameter int unsigned NUM_REGS    = 16,
  parameter int unsigned REG_W       = 16,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDX_W      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  desig_n,
  input  logic [IDX_W-1:0]  desig_p,
  input  logic [IDX_W-1:0]  desig_x,
  input  logic [1:0]        src_sel,
  input  logic [2:0]        op,
  input  logic              byte_hi,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [REG_W-1:0]  addr_out,
  output logic [BYTE_W-1:0] byte_out
);

  localparam int unsigned HI_LSB = REG_W - BYTE_W;

  logic             rst_q_n;
  logic [IDX_W-1:0] sel_idx;
  logic [REG_W-1:0] rd_val;
  logic [REG_W-1:0] nxt_val;
  logic             wr_en;

  spad_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  spad_index_mux #(.IDX_W(IDX_W)) u_index_mux (
    .src_sel (src_sel),
    .desig_n (desig_n),
    .desig_p (desig_p),
    .desig_x (desig_x),
    .idx     (sel_idx)
  );

  spad_update #(.REG_W(REG_W), .BYTE_W(BYTE_W)) u_update (
    .op      (op),
    .cur     (rd_val),
    .byte_in (byte_in),
    .nxt     (nxt_val),
    .wr_en   (wr_en)
  );

  spad_storage #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .IDX_W(IDX_W)) u_storage (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .wr_en   (wr_en),
    .idx     (sel_idx),
    .wr_data (nxt_val),
    .rd_data (rd_val)
  );

  assign addr_out = rd_val;

  always_comb begin
    if (byte_hi) begin
      byte_out = rd_val[REG_W-1:HI_LSB];
    end else begin
      byte_out = rd_val[BYTE_W-1:0];
    end
  end

endmodule

// File: rtl/spad_regfile_chk.sv
module spad_regfile_chk #(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic [IDX_W-1:0]  desig_n,
  input logic [IDX_W-1:0]  desig_p,
  input logic [IDX_W-1:0]  desig_x,
  input logic [1:0]        src_sel,
  input logic [2:0]        op,
  input logic              byte_hi,
  input logic [BYTE_W-1:0] byte_in,
  input logic [REG_W-1:0]  addr_out,
  input logic [BYTE_W-1:0] byte_out
);

  localparam int unsigned HI_LSB = REG_W - BYTE_W;

  logic [IDX_W-1:0] chk_idx;
  logic             primed;

  always_comb begin
    case (src_sel)
      2'd1:    chk_idx = desig_p;
      2'd2:    chk_idx = desig_x;
      default: chk_idx = desig_n;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      primed <= 1'b0;
    end else begin
      primed <= 1'b1;
    end
  end

  AST_BYTE_ROUTE: assert property (@(posedge clk) disable iff (!rst_q_n)
    byte_out == (byte_hi ? addr_out[REG_W-1:HI_LSB] : addr_out[BYTE_W-1:0])); // R4

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    primed && $past(op) == 3'd1 && chk_idx == $past(chk_idx)
    |-> addr_out == $past(addr_out) + REG_W'(1)); // R5

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    primed && $past(op) == 3'd2 && chk_idx == $past(chk_idx)
    |-> addr_out == $past(addr_out) - REG_W'(1)); // R6

  AST_LOAD_LOW: assert property (@(posedge clk) disable iff (!rst_q_n)
    primed && $past(op) == 3'd3 && chk_idx == $past(chk_idx)
    |-> addr_out == {$past(addr_out[REG_W-1:BYTE_W]), $past(byte_in)}); // R7

  AST_LOAD_HIGH: assert property (@(posedge clk) disable iff (!rst_q_n)
    primed && $past(op) == 3'd4 && chk_idx == $past(chk_idx)
    |-> addr_out == {$past(byte_in), $past(addr_out[HI_LSB-1:0])}); // R8

  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    primed && ($past(op) == 3'd0 || $past(op) > 3'd4) && chk_idx == $past(chk_idx)
    |-> $stable(addr_out)); // R9

endmodule

bind spad_regfile spad_regfile_chk #(
  .REG_W  (REG_W),
  .BYTE_W (BYTE_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk      (clk),
  .rst_q_n  (rst_q_n),
  .desig_n  (desig_n),
  .desig_p  (desig_p),
  .desig_x  (desig_x),
  .src_sel  (src_sel),
  .op       (op),
  .byte_hi  (byte_hi),
  .byte_in  (byte_in),
  .addr_out (addr_out),
  .byte_out (byte_out)
);

// File: tb/test_spad_regfile.sv
module test_spad_regfile;

  logic       clk;
  logic       rst_n;
  logic [3:0] desig_n, desig_p, desig_x;
  logic [1:0] src_sel;
  logic [2:0] op;
  logic       byte_hi;
  logic [7:0] byte_in;
  logic [15:0] addr_out;
  logic [7:0]  byte_out;

  typedef struct {
    logic [15:0] addr;
    logic [7:0]  bval;
    string       req;
  } exp_t;

  exp_t   sb_q[$];
  event   sample_ev;
  int     checks = 0;
  int     errors = 0;
  logic [15:0] model [16];

  spad_regfile i_spad_regfile (
    .clk      (clk),
    .rst_n    (rst_n),
    .desig_n  (desig_n),
    .desig_p  (desig_p),
    .desig_x  (desig_x),
    .src_sel  (src_sel),
    .op       (op),
    .byte_hi  (byte_hi),
    .byte_in  (byte_in),
    .addr_out (addr_out),
    .byte_out (byte_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Monitor: pops an expected item whenever the driver signals one.
  initial begin
    forever begin
      @(sample_ev);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (addr_out !== e.addr || byte_out !== e.bval) begin
          errors++;
          $display("FAIL %s addr actual %h expected %h, byte actual %h expected %h",
                   e.req, addr_out, e.addr, byte_out, e.bval);
        end
      end
    end
  end

  // Driver: applies one cycle of stimulus, pushes the expected outputs
  // of this cycle, then advances the bench model past the clock edge.
  task automatic step(input logic [1:0] s, input logic [3:0] n, input logic [3:0] p,
                      input logic [3:0] x, input logic [2:0] o, input logic hi,
                      input logic [7:0] b, input string req);
    logic [3:0]  k;
    logic [15:0] v;
    exp_t e;
    @(negedge clk);
    src_sel = s; desig_n = n; desig_p = p; desig_x = x;
    op = o; byte_hi = hi; byte_in = b;
    #1;
    k = (s == 2'd1) ? p : (s == 2'd2) ? x : n;
    v = model[k];
    e.addr = v;
    e.bval = hi ? v[15:8] : v[7:0];
    e.req  = req;
    sb_q.push_back(e);
    -> sample_ev;
    case (o)
      3'd1: model[k] = v + 16'd1;
      3'd2: model[k] = v - 16'd1;
      3'd3: model[k] = {v[15:8], b};
      3'd4: model[k] = {b, v[7:0]};
      default: ;
    endcase
    @(posedge clk);
  endtask

  // Read register r through designator N with no operation.
  task automatic rd(input logic [3:0] r, input logic hi, input string req);
    step(2'd0, r, 4'd0, 4'd0, 3'd0, hi, 8'h00, req);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual run still going, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 16'h0000;
    rst_n = 1'b0;
    src_sel = 2'd0; desig_n = 4'd0; desig_p = 4'd0; desig_x = 4'd0;
    op = 3'd0; byte_hi = 1'b0; byte_in = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (addr_out !== 16'h0000) begin
      errors++;
      $display("FAIL R1 during reset actual %h expected 0000", addr_out);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: every register reads zero after reset, both bytes.
    for (int i = 0; i < 16; i++) rd(4'(i), i[0], "R1 reset value");

    // R7, R8: build values by byte loads through different designators (R2).
    step(2'd1, 4'd0, 4'd3, 4'd0, 3'd3, 1'b0, 8'h34, "R7 load low via P");
    step(2'd1, 4'd0, 4'd3, 4'd0, 3'd4, 1'b1, 8'h12, "R8 load high via P");
    rd(4'd3, 1'b1, "R8 R3 read back 1234 high byte");
    rd(4'd3, 1'b0, "R4 R3 low byte of 1234");
    step(2'd2, 4'd0, 4'd0, 4'd9, 3'd4, 1'b0, 8'hAB, "R8 load high via X");
    step(2'd2, 4'd0, 4'd0, 4'd9, 3'd3, 1'b0, 8'hCD, "R7 load low via X");
    rd(4'd9, 1'b1, "R3 R4 read ABCD");
    // R7 keeps high byte, R8 keeps low byte.
    step(2'd0, 4'd9, 4'd0, 4'd0, 3'd3, 1'b0, 8'h5A, "R7 low replaced, high kept");
    rd(4'd9, 1'b0, "R7 result AB5A");

    // R2: selection codes, including code 3 behaving as N.
    step(2'd3, 4'd3, 4'd9, 4'd9, 3'd0, 1'b0, 8'h00, "R2 code 3 selects N");
    step(2'd1, 4'd9, 4'd3, 4'd9, 3'd0, 1'b1, 8'h00, "R2 code 1 selects P");
    step(2'd2, 4'd9, 4'd9, 4'd3, 3'd0, 1'b0, 8'h00, "R2 code 2 selects X");

    // R5: increment and wrap; R10: same-cycle read shows old value.
    step(2'd0, 4'd5, 4'd0, 4'd0, 3'd3, 1'b0, 8'hFF, "R7 prep low FF");
    step(2'd0, 4'd5, 4'd0, 4'd0, 3'd4, 1'b0, 8'hFF, "R8 prep high FF");
    step(2'd0, 4'd5, 4'd0, 4'd0, 3'd1, 1'b1, 8'h00, "R10 R5 inc cycle shows FFFF");
    rd(4'd5, 1'b0, "R5 wrap to 0000");
    step(2'd1, 4'd0, 4'd5, 4'd0, 3'd1, 1'b0, 8'h00, "R5 inc via P");
    rd(4'd5, 1'b0, "R5 result 0001");

    // R6: decrement and wrap.
    step(2'd2, 4'd0, 4'd0, 4'd7, 3'd2, 1'b0, 8'h00, "R10 R6 dec cycle shows 0000");
    rd(4'd7, 1'b1, "R6 wrap to FFFF");
    step(2'd0, 4'd7, 4'd0, 4'd0, 3'd2, 1'b0, 8'h00, "R6 dec FFFF");
    rd(4'd7, 1'b0, "R6 result FFFE");

    // R9: no-write codes and unselected registers.
    step(2'd0, 4'd3, 4'd0, 4'd0, 3'd5, 1'b0, 8'hEE, "R9 code 5");
    step(2'd0, 4'd3, 4'd0, 4'd0, 3'd6, 1'b0, 8'hEE, "R9 code 6");
    step(2'd0, 4'd3, 4'd0, 4'd0, 3'd7, 1'b1, 8'hEE, "R9 code 7");
    step(2'd0, 4'd3, 4'd0, 4'd0, 3'd0, 1'b0, 8'hEE, "R9 code 0");
    rd(4'd3, 1'b0, "R9 reg 3 still 1234");
    for (int i = 0; i < 16; i++) rd(4'(i), 1'b1, "R9 whole array unchanged by others");

    // R10: back-to-back writes to one register, read each cycle.
    step(2'd0, 4'd12, 4'd0, 4'd0, 3'd3, 1'b0, 8'h0F, "R10 load cycle shows 0000");
    step(2'd0, 4'd12, 4'd0, 4'd0, 3'd1, 1'b0, 8'h00, "R10 inc cycle shows 000F");
    step(2'd0, 4'd12, 4'd0, 4'd0, 3'd1, 1'b0, 8'h00, "R10 inc cycle shows 0010");
    rd(4'd12, 1'b0, "R10 R5 final 0011");

    @(negedge clk);
    #2;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule